// File: doc/BRIEF.md
# Trace Line Fill Buffer

This block sits between the commit stage of a processor and the write port of a trace cache. It gathers retired instructions, in commit order, into a pending trace line. It follows basic-block boundaries and branch directions as the instructions arrive. When a line is complete, it presents the line to the cache in a single write.

A line closes on whichever of two limits comes first:
- the instruction limit, 16 by default;
- the branch limit, meaning the branch that completes the third basic block.

The completed line carries its start address, the instruction words, the instruction count, the basic-block count and one direction bit per branch.

Both sides are valid/ready streams:
- **Commit side.** The commit side offers one instruction per cycle. An instruction transfers on a cycle where `in_valid` and `in_ready` are both high.
- **Cache side.** A completed line sits in an output register with `line_valid` high until the cache raises `line_ready`. When the cache is already ready, `line_valid` is a one-cycle write strobe.
- **Back-pressure.** While a finished line is waiting and the cache is not ready, `in_ready` is low and commit stalls. The instruction accepted in the cycle the line is written becomes the first instruction of the next line.

Top module: `trace_fill_buffer`

## Requirements
- R1: After reset, `line_valid` is 0 and `in_ready` is 1.
- R2: A line closes on the accepted instruction that brings its instruction count to MAX_INSNS (16), and `line_count` then reads 16.
- R3: A line closes on the accepted branch that is the MAX_BLOCKS-th (3rd) branch of the line. `line_blocks` is the number of branches in the line, plus 1 if the last instruction of the line is not a branch.
- R4: Bit k of `line_outcomes` (bit 0 first) is the taken flag of the k-th branch of the line (1 = taken, 0 = not taken). Bits at or beyond the line's branch count are 0.
- R5: `line_start_pc` is the PC of the first instruction accepted after the previous line closed, or after reset.
- R6: Slot i of `line_words` (bits i*32 upward) holds the word of the i-th instruction of the line. Slots at or beyond `line_count` are 0.
- R7: While `line_valid` is 1 and `line_ready` is 0, `line_valid` stays 1 and every line field holds its value. A line is presented exactly once, and in order.
- R8: `in_ready` equals NOT `line_valid` OR `line_ready`. No instruction is taken while `in_ready` is 0.
- R9: An instruction accepted in the same cycle a line is written to the cache is the first instruction of the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Commit stream carries an instruction |
| in_ready | output | 1 | Buffer can take an instruction this cycle |
| in_pc | input | PC_W | PC of the committed instruction |
| in_insn | input | INSN_W | Instruction word |
| in_is_branch | input | 1 | Instruction is a conditional or unconditional branch |
| in_taken | input | 1 | Branch direction (1 = taken); ignored for non-branches |
| line_valid | output | 1 | A completed line is offered to the cache |
| line_ready | input | 1 | Cache write port accepts the line |
| line_start_pc | output | PC_W | Start address of the line |
| line_words | output | MAX_INSNS*INSN_W | Instruction words, slot 0 in the low bits |
| line_count | output | CNT_W | Number of instructions in the line |
| line_blocks | output | BLK_W | Number of basic blocks in the line |
| line_outcomes | output | MAX_BLOCKS | Branch direction bits, first branch in bit 0 |

## Verification
The block is driven with four input patterns, each telling a different closing rule or path apart:
- **Straight-line code.** Runs with no branches can only close on the instruction limit, so they isolate the 16-instruction rule and the trailing-block count.
- **Back-to-back branches.** Streams made entirely of branches close after three instructions, which isolates the branch limit and the outcome-bit ordering.
- **Mixed streams with a stalling cache.** These cross both limits with arbitrary branch spacing while `line_ready` drops at random. This separates correct stalling and field holding from lines that are lost or duplicated.
- **Sparse input with a ready cache.** Idle gaps on the input side show that only accepted instructions count, and that an instruction accepted in a write cycle starts the next line.

// File: rtl/tfb_pkg.sv
package tfb_pkg;
  localparam int TFB_PC_W       = 32;
  localparam int TFB_INSN_W     = 32;
  localparam int TFB_MAX_INSNS  = 16;
  localparam int TFB_MAX_BLOCKS = 3;

  typedef enum logic [1:0] {
    CLOSE_NONE   = 2'd0,
    CLOSE_INSNS  = 2'd1,
    CLOSE_BLOCKS = 2'd2
  } close_cause_e;
endpackage

// File: rtl/tfb_accum.sv
module tfb_accum
  import tfb_pkg::*;
#(
  parameter int PC_W       = TFB_PC_W,
  parameter int INSN_W     = TFB_INSN_W,
  parameter int MAX_INSNS  = TFB_MAX_INSNS,
  parameter int MAX_BLOCKS = TFB_MAX_BLOCKS,
  localparam int CNT_W     = $clog2(MAX_INSNS + 1),
  localparam int BLK_W     = $clog2(MAX_BLOCKS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        accept,
  input  logic [PC_W-1:0]             pc,
  input  logic [INSN_W-1:0]           insn,
  input  logic                        is_branch,
  input  logic                        taken,
  output logic                        close,
  output close_cause_e                cause,
  output logic [CNT_W-1:0]            fill_cnt,
  output logic [PC_W-1:0]             cl_start_pc,
  output logic [MAX_INSNS*INSN_W-1:0] cl_words,
  output logic [CNT_W-1:0]            cl_count,
  output logic [BLK_W-1:0]            cl_blocks,
  output logic [MAX_BLOCKS-1:0]       cl_outcomes
);
  logic [CNT_W-1:0]      cnt_q, cnt_next;
  logic [BLK_W-1:0]      brs_q, brs_next;
  logic [MAX_BLOCKS-1:0] outc_q, outc_next;
  logic [PC_W-1:0]       start_q;
  logic [INSN_W-1:0]     words_q [MAX_INSNS];
  logic                  hit_insns, hit_blocks;

  assign cnt_next   = cnt_q + CNT_W'(1);
  assign brs_next   = brs_q + BLK_W'(is_branch);
  assign outc_next  = outc_q | (MAX_BLOCKS'(is_branch & taken) << brs_q);
  assign hit_insns  = (cnt_next == CNT_W'(MAX_INSNS));
  assign hit_blocks = is_branch && (brs_next == BLK_W'(MAX_BLOCKS));
  assign close      = accept && (hit_insns || hit_blocks);

  always_comb begin
    if (!close)          cause = CLOSE_NONE;
    else if (hit_blocks) cause = CLOSE_BLOCKS;
    else                 cause = CLOSE_INSNS;
  end

  // Line as it stands after the current instruction is added
  assign cl_start_pc = (cnt_q == '0) ? pc : start_q;
  assign cl_count    = cnt_next;
  assign cl_blocks   = brs_next + (is_branch ? BLK_W'(0) : BLK_W'(1));
  assign cl_outcomes = outc_next;
  assign fill_cnt    = cnt_q;

  for (genvar i = 0; i < MAX_INSNS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (accept && cnt_q == CNT_W'(i)) words_q[i] <= insn;
    end
    always_comb begin
      if (cnt_q == CNT_W'(i))     cl_words[i*INSN_W +: INSN_W] = insn;
      else if (cnt_q > CNT_W'(i)) cl_words[i*INSN_W +: INSN_W] = words_q[i];
      else                        cl_words[i*INSN_W +: INSN_W] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      brs_q   <= '0;
      outc_q  <= '0;
      start_q <= '0;
    end else if (accept) begin
      if (close) begin
        cnt_q  <= '0;
        brs_q  <= '0;
        outc_q <= '0;
      end else begin
        cnt_q  <= cnt_next;
        brs_q  <= brs_next;
        outc_q <= outc_next;
        if (cnt_q == '0) start_q <= pc;
      end
    end
  end

  p_fill_below_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(MAX_INSNS));
  p_branches_below_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    brs_q < BLK_W'(MAX_BLOCKS));
  p_close_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> (cnt_q == '0) && (outc_q == '0));
endmodule

// File: rtl/tfb_out_stage.sv
module tfb_out_stage #(
  parameter int PC_W       = 32,
  parameter int WORDS_W    = 512,
  parameter int CNT_W      = 5,
  parameter int BLK_W      = 2,
  parameter int MAX_BLOCKS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [PC_W-1:0]       d_start_pc,
  input  logic [WORDS_W-1:0]    d_words,
  input  logic [CNT_W-1:0]      d_count,
  input  logic [BLK_W-1:0]      d_blocks,
  input  logic [MAX_BLOCKS-1:0] d_outcomes,
  output logic                  free,
  output logic                  q_valid,
  input  logic                  q_ready,
  output logic [PC_W-1:0]       q_start_pc,
  output logic [WORDS_W-1:0]    q_words,
  output logic [CNT_W-1:0]      q_count,
  output logic [BLK_W-1:0]      q_blocks,
  output logic [MAX_BLOCKS-1:0] q_outcomes
);
  assign free = !q_valid || q_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_valid <= 1'b0;
    else if (load)    q_valid <= 1'b1;
    else if (q_ready) q_valid <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_start_pc <= '0;
      q_words    <= '0;
      q_count    <= '0;
      q_blocks   <= '0;
      q_outcomes <= '0;
    end else if (load) begin
      q_start_pc <= d_start_pc;
      q_words    <= d_words;
      q_count    <= d_count;
      q_blocks   <= d_blocks;
      q_outcomes <= d_outcomes;
    end
  end

  p_load_only_when_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> free);
  p_hold_while_waiting_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_ready) |=> q_valid && $stable(q_start_pc) && $stable(q_count)
                              && $stable(q_blocks) && $stable(q_outcomes) && $stable(q_words));
endmodule

// File: rtl/trace_fill_buffer.sv
module trace_fill_buffer
  import tfb_pkg::*;
#(
  parameter int PC_W       = TFB_PC_W,
  parameter int INSN_W     = TFB_INSN_W,
  parameter int MAX_INSNS  = TFB_MAX_INSNS,
  parameter int MAX_BLOCKS = TFB_MAX_BLOCKS,
  localparam int CNT_W     = $clog2(MAX_INSNS + 1),
  localparam int BLK_W     = $clog2(MAX_BLOCKS + 1),
  localparam int WORDS_W   = MAX_INSNS * INSN_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [PC_W-1:0]       in_pc,
  input  logic [INSN_W-1:0]     in_insn,
  input  logic                  in_is_branch,
  input  logic                  in_taken,
  output logic                  line_valid,
  input  logic                  line_ready,
  output logic [PC_W-1:0]       line_start_pc,
  output logic [WORDS_W-1:0]    line_words,
  output logic [CNT_W-1:0]      line_count,
  output logic [BLK_W-1:0]      line_blocks,
  output logic [MAX_BLOCKS-1:0] line_outcomes
);
  logic                  accept, close;
  close_cause_e          cause;
  logic [CNT_W-1:0]      fill_cnt;
  logic [PC_W-1:0]       cl_start_pc;
  logic [WORDS_W-1:0]    cl_words;
  logic [CNT_W-1:0]      cl_count;
  logic [BLK_W-1:0]      cl_blocks;
  logic [MAX_BLOCKS-1:0] cl_outcomes;

  assign accept = in_valid && in_ready;

  tfb_accum #(
    .PC_W(PC_W), .INSN_W(INSN_W), .MAX_INSNS(MAX_INSNS), .MAX_BLOCKS(MAX_BLOCKS)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .pc(in_pc), .insn(in_insn), .is_branch(in_is_branch), .taken(in_taken),
    .close(close), .cause(cause), .fill_cnt(fill_cnt),
    .cl_start_pc(cl_start_pc), .cl_words(cl_words), .cl_count(cl_count),
    .cl_blocks(cl_blocks), .cl_outcomes(cl_outcomes)
  );

  tfb_out_stage #(
    .PC_W(PC_W), .WORDS_W(WORDS_W), .CNT_W(CNT_W), .BLK_W(BLK_W), .MAX_BLOCKS(MAX_BLOCKS)
  ) u_out (
    .clk(clk), .rst_n(rst_n), .load(close),
    .d_start_pc(cl_start_pc), .d_words(cl_words), .d_count(cl_count),
    .d_blocks(cl_blocks), .d_outcomes(cl_outcomes),
    .free(in_ready), .q_valid(line_valid), .q_ready(line_ready),
    .q_start_pc(line_start_pc), .q_words(line_words), .q_count(line_count),
    .q_blocks(line_blocks), .q_outcomes(line_outcomes)
  );

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !line_valid);
  p_count_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> (line_count != '0) && (line_count <= CNT_W'(MAX_INSNS)));
  p_blocks_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> (line_blocks != '0) && (line_blocks <= BLK_W'(MAX_BLOCKS)));
  p_outcomes_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> ($countones(line_outcomes) <= int'(line_blocks)));
  p_stall_freezes_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && !line_ready) |=> $stable(fill_cnt));
  p_cause_matches_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == CLOSE_BLOCKS) |=> line_valid && (line_blocks == BLK_W'(MAX_BLOCKS)));
endmodule

// File: tb/trace_fill_buffer_bench.sv
module trace_fill_buffer_bench;
  localparam int PC_W = 32, INSN_W = 32, MAXI = 16, MAXB = 3;
  localparam int CNT_W = $clog2(MAXI + 1), BLK_W = $clog2(MAXB + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_is_branch = 1'b0, in_taken = 1'b0, line_ready = 1'b0;
  logic [PC_W-1:0] in_pc = '0;
  logic [INSN_W-1:0] in_insn = '0;
  logic in_ready, line_valid;
  logic [PC_W-1:0] line_start_pc;
  logic [MAXI*INSN_W-1:0] line_words;
  logic [CNT_W-1:0] line_count;
  logic [BLK_W-1:0] line_blocks;
  logic [MAXB-1:0] line_outcomes;

  trace_fill_buffer u_trace_fill_buffer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .in_insn(in_insn), .in_is_branch(in_is_branch), .in_taken(in_taken),
    .line_valid(line_valid), .line_ready(line_ready), .line_start_pc(line_start_pc),
    .line_words(line_words), .line_count(line_count), .line_blocks(line_blocks),
    .line_outcomes(line_outcomes)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model state
  logic [INSN_W-1:0] q_words[$];
  logic [PC_W-1:0]   m_start;
  int                m_brs;
  int                m_outc;
  bit                mo_valid;
  logic [PC_W-1:0]   mo_start;
  logic [MAXI*INSN_W-1:0] mo_words;
  int                mo_count, mo_blocks, mo_outc;
  logic [PC_W-1:0]   next_pc = 32'h0000_1000;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_outputs();
    chk("R8", "in_ready", in_ready, (!mo_valid || line_ready));
    chk("R7", "line_valid", line_valid, mo_valid);
    if (mo_valid && line_valid) begin
      chk("R5", "start_pc", line_start_pc, mo_start);
      chk("R2", "count", line_count, mo_count);
      chk("R3", "blocks", line_blocks, mo_blocks);
      chk("R4", "outcomes", line_outcomes, mo_outc);
      checks++;
      if (line_words !== mo_words) begin
        errors++;
        $display("FAIL R6 words: actual=%0h expected=%0h", line_words, mo_words);
      end
    end
  endtask

  // Apply the cycle's inputs to the model (what the next posedge does)
  task automatic model_step();
    bit rdy;
    bit acc;
    rdy = !mo_valid || line_ready;
    acc = in_valid && rdy;
    if (mo_valid && line_ready) mo_valid = 0;
    if (acc) begin
      q_words.push_back(in_insn);
      if (q_words.size() == 1) m_start = in_pc;
      if (in_is_branch) begin
        if (in_taken) m_outc |= (1 << m_brs);
        m_brs++;
      end
      if (q_words.size() == MAXI || (in_is_branch && m_brs == MAXB)) begin
        mo_valid  = 1;
        mo_start  = m_start;
        mo_count  = q_words.size();
        mo_blocks = m_brs + (in_is_branch ? 0 : 1);
        mo_outc   = m_outc;
        mo_words  = '0;
        foreach (q_words[k]) mo_words[k*INSN_W +: INSN_W] = q_words[k];
        q_words.delete();
        m_brs = 0;
        m_outc = 0;
      end
    end
  endtask

  // mode 0: straight-line, 1: all branches, 2: mixed + stalling cache, 3: sparse, ready cache
  task automatic run_phase(input int mode, input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      compare_outputs();
      case (mode)
        0: begin in_valid = 1; in_is_branch = 0; line_ready = ($urandom % 4) != 0; end
        1: begin in_valid = 1; in_is_branch = 1; line_ready = 1; end
        2: begin in_valid = ($urandom % 5) != 0; in_is_branch = ($urandom % 4) == 0;
                 line_ready = ($urandom % 3) != 0; end
        default: begin in_valid = ($urandom % 3) == 0; in_is_branch = ($urandom % 6) == 0;
                 line_ready = 1; end
      endcase
      in_taken = $urandom % 2;
      in_pc    = next_pc;
      in_insn  = $urandom;
      next_pc  = next_pc + 4;
      model_step();
    end
  endtask

  initial begin
    q_words.delete();
    m_brs = 0; m_outc = 0; mo_valid = 0; m_start = '0;
    mo_start = '0; mo_words = '0; mo_count = 0; mo_blocks = 0; mo_outc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "line_valid after reset", line_valid, 0);
    chk("R1", "in_ready after reset", in_ready, 1);
    run_phase(0, 200);   // R2: instruction limit, R7 holding
    run_phase(1, 60);    // R3 and R4: branch limit, outcome order
    run_phase(2, 3000);  // R5, R6, R7, R8 with back-pressure
    run_phase(3, 1500);  // R9: accepts in write cycles, idle gaps
    @(negedge clk);
    in_valid = 0;
    compare_outputs();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule